// File: doc/BRIEF.md
# Three-Phase Sine Sample Sequencer

This block produces three sine waveforms spaced 120 degrees apart for a quad parallel DAC. It holds a 256-entry sine table of 8-bit offset-binary codes, keeps one base pointer into it, and derives three channel indices from it. These indices sit one third and two thirds of the table ahead of the base. Each sample step is a triad of three writes, one for each of channels A, B and C. The triad goes out through a single shared write port that uses a request/acknowledge handshake toward a downstream DAC write controller.

A programmable period counter sets how often a triad may begin, and so sets the output frequency. One full waveform cycle is 256 triads, which is about 1.4 degrees per step. The run-enable level starts and stops the stream. When run-enable falls, the triad already under way is allowed to finish. A restart pulse returns the base pointer to index zero, so all three phases can be realigned.

Top module: `tri_sine_seq`

## Requirements
- R1: After reset no write is requested, and the first triad issued after reset uses base index 0.
- R2: The sample code for table index i is round(127.5 + 127.5*sin(2*pi*i/256)), clipped to 0..255. Index 0 gives 128, index 64 gives 255 and index 192 gives 0.
- R3: Within a triad, channel A carries the code at base, channel B the code at (base+85) mod 256, and channel C the code at (base+171) mod 256.
- R4: The three writes of a triad are issued in the order A, B, C on `wr_addr` codes 0, 1 and 2. Code 3 is never requested.
- R5: While `wr_req` is high and `wr_ack` is low, `wr_req`, `wr_addr` and `wr_data` stay unchanged.
- R6: The base index increases by one only once the third write of a triad has been accepted, and it wraps from 255 to 0.
- R7: A triad may begin only after the period counter has expired, and the counter expires every `period` cycles (0 behaves as 1). With `wr_ack` held high and `period` of 4 or more, the first writes of consecutive triads are exactly `period` cycles apart.
- R8: If the period expires while a triad is still in progress, the next triad waits and is not skipped. With `wr_ack` held high and `period` below 4, consecutive triads are 4 cycles apart, and no base index is missed.
- R9: When `run_en` goes low, a triad already under way completes, and no further request is made while `run_en` stays low.
- R10: A `restart` pulse while idle sets the base index to 0 at once. A pulse during a triad lets that triad finish with its own index and makes the next triad start at base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Level enable for triad generation |
| restart | input | 1 | One-cycle pulse that returns the base index to 0 |
| period | input | PERIOD_W | Cycles between period expiries |
| wr_req | output | 1 | Write request toward the DAC write controller |
| wr_addr | output | 2 | Channel select: 0 = A, 1 = B, 2 = C |
| wr_data | output | 8 | Offset-binary sample code |
| wr_ack | input | 1 | Write accepted in this cycle when high together with `wr_req` |

## Verification
The bench builds the block with `PERIOD_W` = 6. This narrow counter lets the bench cover periods of 1, 2, 3 and 5 cycles in a short run. Those values sit on both sides of the 4-cycle triad length, so they exercise both the exact-spacing case and the case where the next triad has to wait. A 260-triad run at period 1 walks the whole table and crosses the 255-to-0 wrap. Acknowledge patterns that are always high, periodically low, or held low make the handshake hold and a restart arriving during a triad reachable.

// File: rtl/tri_sine_seq.sv
`timescale 1ns/1ps
module tri_sine_seq #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic                wr_req,
  output logic [1:0]          wr_addr,
  output logic [7:0]          wr_data,
  input  logic                wr_ack
);
  localparam int TBL_N  = 256;
  localparam logic [7:0] OFS_B = 8'd85;
  localparam logic [7:0] OFS_C = 8'd171;

  function automatic logic [7:0] sine_code(input int i);
    real v;
    int  r;
    v = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * real'(i) / real'(TBL_N));
    r = $rtoi(v + 0.5);
    if (r < 0)   r = 0;
    if (r > 255) r = 255;
    return 8'(r);
  endfunction

  logic [7:0] tbl [TBL_N];
  for (genvar g = 0; g < TBL_N; g++) begin : g_rom
    localparam logic [7:0] CODE = sine_code(g);
    assign tbl[g] = CODE;
  end

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W:0]   cnt_nx;
  logic                tick, due, busy, restart_pend, launch, accept, last;
  logic [1:0]          slot;
  logic [7:0]          base, ofs, idx;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign tick   = run_en && (cnt_nx >= {1'b0, period});
  assign launch = run_en && due && !busy;
  assign accept = busy && wr_ack;
  assign last   = accept && (slot == 2'd2);

  always_comb begin
    case (slot)
      2'd0:    ofs = 8'd0;
      2'd1:    ofs = OFS_B;
      default: ofs = OFS_C;
    endcase
  end
  assign idx = base + ofs;

  assign wr_req  = busy;
  assign wr_addr = slot;
  assign wr_data = tbl[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      due          <= 1'b0;
      busy         <= 1'b0;
      slot         <= 2'd0;
      base         <= 8'd0;
      restart_pend <= 1'b0;
    end else begin
      cnt <= (!run_en || tick) ? '0 : cnt + 1'b1;

      if (!run_en)    due <= 1'b0;
      else if (tick)  due <= 1'b1;
      else if (launch) due <= 1'b0;

      if (launch) begin
        busy <= 1'b1;
        slot <= 2'd0;
      end else if (last) begin
        busy <= 1'b0;
        slot <= 2'd0;
      end else if (accept) begin
        slot <= slot + 2'd1;
      end

      if (last) begin
        base         <= (restart_pend || restart) ? 8'd0 : base + 8'd1;
        restart_pend <= 1'b0;
      end else if (restart) begin
        if (busy) restart_pend <= 1'b1;
        else      base <= 8'd0;
      end
    end
  end

  assert_addr_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr != 2'd3);

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && wr_addr != 2'd2) |=> (wr_req && wr_addr == 2'($past(wr_addr) + 2'd1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_triad_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && wr_addr == 2'd2) |=> !wr_req);

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_req) |=> !wr_req);
endmodule

// File: tb/tri_sine_seq_test.sv
`timescale 1ns/1ps
module tri_sine_seq_test;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0;
  logic          restart = 1'b0;
  logic [PW-1:0] period = '0;
  logic          wr_ack = 1'b0;
  logic          wr_req;
  logic [1:0]    wr_addr;
  logic [7:0]    wr_data;

  tri_sine_seq #(.PERIOD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart(restart), .period(period),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int ack_mode = 0;
  int first_cnt = 0;
  int spacing_exp = 0;
  int last_first = -1;
  string cur_tag = "R1";
  logic [9:0] expq[$];
  logic       hold_valid = 1'b0;
  logic [9:0] hold_item = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sine_ref(input int i);
    real v;
    int  r;
    v = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * real'(i) / 256.0);
    r = $rtoi(v + 0.5);
    if (r < 0)   r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_triad(input int b);
    for (int s = 0; s < 3; s++) begin
      int ix;
      ix = (b + (s == 0 ? 0 : (s == 1 ? 85 : 171))) % 256;
      expq.push_back({2'(s), 8'(sine_ref(ix))});
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    case (ack_mode)
      0:       wr_ack = 1'b1;
      1:       wr_ack = (cyc % 3) != 1;
      default: wr_ack = 1'b0;
    endcase
  end

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (hold_valid)
        check(wr_req && {wr_addr, wr_data} == hold_item, "R5", "held request changed",
              {wr_req, wr_addr, wr_data}, {1'b1, hold_item});
      hold_valid = wr_req && !wr_ack;
      hold_item  = {wr_addr, wr_data};
      if (wr_req && wr_ack) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected write addr", wr_addr, -1);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          check(wr_addr == e[9:8], "R4", {cur_tag, " channel order"}, wr_addr, e[9:8]);
          check(wr_data == e[7:0], "R3", {cur_tag, " R2 R6 sample code"}, wr_data, e[7:0]);
        end
        if (wr_addr == 2'd0) begin
          first_cnt++;
          if (spacing_exp != 0 && last_first >= 0)
            check(cyc - last_first == spacing_exp, "R7", {cur_tag, " triad spacing"},
                  cyc - last_first, spacing_exp);
          last_first = cyc;
        end
      end
    end
  end

  task automatic finish_run(input int n);
    while (first_cnt < n) @(negedge clk);
    @(posedge clk); #1 run_en = 1'b0;
    repeat (40) @(posedge clk);
    check(expq.size() == 0, "R9", {cur_tag, " pending expected writes"}, expq.size(), 0);
  endtask

  task automatic run_test(input int p, input int amode, input bit do_restart, input int b0,
                          input int n, input int spacing, input string tag);
    cur_tag = tag;
    period = PW'(p);
    ack_mode = amode;
    spacing_exp = spacing;
    last_first = -1;
    first_cnt = 0;
    for (int k = 0; k < n; k++) push_triad((b0 + k) % 256);
    @(posedge clk); #1;
    restart = do_restart;
    run_en = 1'b1;
    @(posedge clk); #1 restart = 1'b0;
    finish_run(n);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (10) begin
        @(negedge clk);
        if (wr_req) seen++;
      end
      check(seen == 0, "R1", "request after reset", seen, 0);
    end

    // R1 R7: no restart, base from reset is 0, period 5 spacing exact
    run_test(5, 0, 1'b0, 0, 6, 5, "R1 R7");
    // R8: period 2 shorter than a triad, base continues at 6
    run_test(2, 0, 1'b0, 6, 4, 4, "R8");
    // R10: restart while idle, stalled acknowledges, period 3
    run_test(3, 1, 1'b1, 0, 8, 0, "R10 R5");

    // R10: restart during a triad held by a low acknowledge
    cur_tag = "R10 deferred";
    period = PW'(4);
    ack_mode = 2;
    spacing_exp = 0;
    last_first = -1;
    first_cnt = 0;
    push_triad(8);
    push_triad(0);
    push_triad(1);
    @(posedge clk); #1 run_en = 1'b1;
    while (!wr_req) @(negedge clk);
    @(posedge clk); #1 restart = 1'b1;
    @(posedge clk); #1 restart = 1'b0;
    ack_mode = 0;
    finish_run(3);

    // R6: full table walk with wrap, period 1
    run_test(1, 0, 1'b1, 0, 260, 4, "R6 R7");

    summary();
  end
endmodule